// File: doc/BRIEF.md
# Balanced Ternary Level Decoder

This block turns a requested output level for a cascaded multilevel converter into one command per stage. The converter has four series stages whose DC weights are 1, 3, 9 and 27 units. Each stage can add its voltage, subtract it, or be bypassed. The block writes the requested signed level as a balanced base-3 number, so the weighted sum of the stage commands equals the request. With four stages, every integer from -40 to +40 can be reached, which gives 3^4 = 81 levels. The lowest-weight stages form a nine-level base step pattern. The heavier stages add or remove steps on top of that pattern.

A signed level is presented together with a one-cycle valid strobe. On that clock edge the block registers all four digit codes at once and pulses a done flag. A request outside the reachable range is clamped to the nearest limit. It also sets a range-error flag that stays set until reset. Dead-time, the power stage and sensing are handled elsewhere.

Top module: `ternLevelDecoder`

## Requirements
- R1: While reset is asserted and after it is released, `digitsOut` is all zero, `doneOut` is 0 and `rangeErr` is 0.
- R2: Stage i occupies `digitsOut[2i+1:2i]` and has weight 3^i. The code 2'b01 means add (+1), 2'b11 means subtract (-1) and 2'b00 means bypass (0).
- R3: For every level from -40 to +40, the weighted sum of the stage digits equals the level.
- R4: The code 2'b10 never appears in any stage field.
- R5: All digit fields update together on the clock edge that samples `levelValid` high. `doneOut` is high for exactly the following cycle.
- R6: While `levelValid` is low, changes on `levelIn` have no effect: `digitsOut` holds its value and `doneOut` stays low.
- R7: A level above +40 yields the digits of +40 (all stages 2'b01). A level below -40 yields the digits of -40 (all stages 2'b11).
- R8: A valid request outside -40..+40 sets `rangeErr`. The flag then stays set through later in-range requests until reset. In-range requests never set it.
- R9: A residue of 2 at any stage is encoded as -1 with a carry of +1 into the next stage. For example, level 2 gives stage 0 = 2'b11 and stage 1 = 2'b01, and level 14 gives stages 3..0 = 01,11,11,11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| levelIn | input | 8 | Requested level, two's complement |
| levelValid | input | 1 | Request strobe, one cycle |
| digitsOut | output | 8 | Four 2-bit stage commands, stage 0 in the low bits |
| doneOut | output | 1 | One-cycle pulse after a request is taken |
| rangeErr | output | 1 | Sticky flag for a clamped request |

## Verification
The hardest cases to reach are carries that ripple through every stage at once, and clamped requests. Only a few values out of the 8-bit input space exercise these, and a walk of the nominal range never touches the clamp. The stimulus targets levels such as ±14 and ±40 for full carry chains. It also drives ±41, +127 and -128 to reach saturation and the sticky flag. Before any of this, it walks all 81 legal levels to show that in-range traffic leaves the flag clear. The bench then changes the input without a strobe to confirm the hold.

// File: rtl/ternLvlPkg.sv
package ternLvlPkg;

  typedef struct packed {
    logic loadDigits;
    logic setErr;
    logic pulseDone;
  } lvlStrobe_t;

  localparam logic [1:0] DIG_ZERO = 2'b00;
  localparam logic [1:0] DIG_POS  = 2'b01;
  localparam logic [1:0] DIG_NEG  = 2'b11;

  // largest magnitude representable by n balanced ternary digits
  function automatic int maxLevel(input int n);
    int p;
    p = 1;
    for (int i = 0; i < n; i++) p = p * 3;
    return (p - 1) / 2;
  endfunction

endpackage

// File: rtl/ternDigitCell.sv
module ternDigitCell #(
  parameter int RES_W = 10
) (
  input  logic signed [RES_W-1:0] resIn,
  output logic signed [RES_W-1:0] resOut,
  output logic [1:0]              digit
);
  import ternLvlPkg::*;

  localparam logic signed [RES_W-1:0] THREE = RES_W'(3);
  localparam logic signed [RES_W-1:0] ONE   = RES_W'(1);

  logic signed [RES_W-1:0] rawRem;
  logic signed [RES_W-1:0] posRem;

  always_comb begin
    rawRem = resIn % THREE;
    posRem = (rawRem < 0) ? rawRem + THREE : rawRem;
    case (posRem)
      ONE: begin
        digit  = DIG_POS;
        resOut = (resIn - ONE) / THREE;
      end
      ONE + ONE: begin
        digit  = DIG_NEG;
        resOut = (resIn + ONE) / THREE;
      end
      default: begin
        digit  = DIG_ZERO;
        resOut = resIn / THREE;
      end
    endcase
  end
endmodule

// File: rtl/ternLvlControl.sv
module ternLvlControl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   levelValid,
  input  logic                   outOfRange,
  output ternLvlPkg::lvlStrobe_t strobe,
  output logic                   doneOut
);
  always_comb begin
    strobe.loadDigits = levelValid;
    strobe.setErr     = levelValid & outOfRange;
    strobe.pulseDone  = levelValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneOut <= 1'b0;
    else       doneOut <= strobe.pulseDone;
  end
endmodule

// File: rtl/ternLvlDatapath.sv
module ternLvlDatapath #(
  parameter int NSTAGE = 4,
  parameter int LVL_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [LVL_W-1:0] levelIn,
  input  ternLvlPkg::lvlStrobe_t  strobe,
  output logic                    outOfRange,
  output logic [2*NSTAGE-1:0]     digitsOut,
  output logic                    rangeErr
);
  import ternLvlPkg::*;

  localparam int RES_W = LVL_W + 2;
  localparam int MAXLVL = maxLevel(NSTAGE);
  localparam logic signed [RES_W-1:0] MAX_S = RES_W'(MAXLVL);
  localparam logic signed [RES_W-1:0] MIN_S = -MAX_S;

  logic signed [RES_W-1:0] lvlWide;
  logic signed [RES_W-1:0] lvlClamped;
  logic signed [RES_W-1:0] resChain [NSTAGE+1];
  logic [2*NSTAGE-1:0]     digitsNext;

  always_comb begin
    lvlWide    = RES_W'(levelIn);
    outOfRange = (lvlWide > MAX_S) || (lvlWide < MIN_S);
    if (lvlWide > MAX_S)      lvlClamped = MAX_S;
    else if (lvlWide < MIN_S) lvlClamped = MIN_S;
    else                      lvlClamped = lvlWide;
  end

  assign resChain[0] = lvlClamped;

  for (genvar g = 0; g < NSTAGE; g++) begin : gStage
    ternDigitCell #(.RES_W(RES_W)) uCell (
      .resIn (resChain[g]),
      .resOut(resChain[g+1]),
      .digit (digitsNext[2*g+1:2*g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitsOut <= '0;
      rangeErr  <= 1'b0;
    end else begin
      if (strobe.loadDigits) digitsOut <= digitsNext;
      if (strobe.setErr)     rangeErr  <= 1'b1;
    end
  end
endmodule

// File: rtl/ternLevelDecoder.sv
module ternLevelDecoder #(
  parameter int NSTAGE = 4,
  parameter int LVL_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [LVL_W-1:0] levelIn,
  input  logic                    levelValid,
  output logic [2*NSTAGE-1:0]     digitsOut,
  output logic                    doneOut,
  output logic                    rangeErr
);
  import ternLvlPkg::*;

  lvlStrobe_t strobe;
  logic       outOfRange;

  ternLvlControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .levelValid(levelValid),
    .outOfRange(outOfRange),
    .strobe    (strobe),
    .doneOut   (doneOut)
  );

  ternLvlDatapath #(.NSTAGE(NSTAGE), .LVL_W(LVL_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .levelIn   (levelIn),
    .strobe    (strobe),
    .outOfRange(outOfRange),
    .digitsOut (digitsOut),
    .rangeErr  (rangeErr)
  );
endmodule

// File: rtl/ternLevelDecoder_chk.sv
module ternLevelDecoder_chk #(
  parameter int NSTAGE = 4,
  parameter int LVL_W  = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [LVL_W-1:0] levelIn,
  input logic                    levelValid,
  input logic [2*NSTAGE-1:0]     digitsOut,
  input logic                    doneOut,
  input logic                    rangeErr
);
  import ternLvlPkg::*;

  localparam int MAXLVL = maxLevel(NSTAGE);

  int weightedSum;
  int satLevel;
  logic inRange;

  always_comb begin
    int w;
    weightedSum = 0;
    w = 1;
    for (int i = 0; i < NSTAGE; i++) begin
      if (digitsOut[2*i +: 2] == DIG_POS) weightedSum = weightedSum + w;
      else if (digitsOut[2*i +: 2] == DIG_NEG) weightedSum = weightedSum - w;
      w = w * 3;
    end
    satLevel = int'(levelIn);
    inRange  = (satLevel <= MAXLVL) && (satLevel >= -MAXLVL);
    if (satLevel > MAXLVL)  satLevel = MAXLVL;
    if (satLevel < -MAXLVL) satLevel = -MAXLVL;
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : gCode
    a_r4_no_bad_code: assert property (@(posedge clk) disable iff (!rstN)
      digitsOut[2*g +: 2] != 2'b10);
  end

  a_r3_sum_matches: assert property (@(posedge clk) disable iff (!rstN)
    levelValid |=> (weightedSum == $past(satLevel)));

  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    levelValid |=> doneOut);

  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(levelValid));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !levelValid |=> $stable(digitsOut));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |=> rangeErr);

  a_r8_set_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rangeErr) |-> ($past(levelValid) && !$past(inRange)));
endmodule

bind ternLevelDecoder ternLevelDecoder_chk #(.NSTAGE(NSTAGE), .LVL_W(LVL_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .levelIn   (levelIn),
  .levelValid(levelValid),
  .digitsOut (digitsOut),
  .doneOut   (doneOut),
  .rangeErr  (rangeErr)
);

// File: tb/sim_ternLevelDecoder.sv
module sim_ternLevelDecoder;
  localparam int NSTAGE = 4;
  localparam int LVL_W  = 8;
  localparam int NVEC   = 14;

  localparam logic signed [7:0] vecLvl [NVEC] = '{
    8'sd0, 8'sd1, -8'sd1, 8'sd2, 8'sd5, 8'sd13, 8'sd14, -8'sd14,
    8'sd40, -8'sd40, 8'sd41, -8'sd41, 8'sd127, -8'sd128};
  localparam logic [7:0] vecDig [NVEC] = '{
    8'h00, 8'h01, 8'h03, 8'h07, 8'h1F, 8'h15, 8'h7F, 8'hD5,
    8'h55, 8'hFF, 8'h55, 8'hFF, 8'h55, 8'hFF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [LVL_W-1:0] levelIn = '0;
  logic levelValid = 1'b0;
  logic [2*NSTAGE-1:0] digitsOut;
  logic doneOut;
  logic rangeErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ternLevelDecoder #(.NSTAGE(NSTAGE), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rstN(rstN), .levelIn(levelIn), .levelValid(levelValid),
    .digitsOut(digitsOut), .doneOut(doneOut), .rangeErr(rangeErr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent reference: offset to unsigned, plain base 3, shift digits down by one
  function automatic logic [7:0] refDigits(input int lvl);
    int u;
    logic [7:0] r;
    u = lvl + 40;
    r = '0;
    for (int i = 0; i < NSTAGE; i++) begin
      case (u % 3)
        0: r[2*i +: 2] = 2'b11;
        1: r[2*i +: 2] = 2'b00;
        default: r[2*i +: 2] = 2'b01;
      endcase
      u = u / 3;
    end
    return r;
  endfunction

  function automatic int sumDigits(input logic [7:0] d, output bit bad);
    int s;
    int w;
    s = 0; w = 1; bad = 1'b0;
    for (int i = 0; i < NSTAGE; i++) begin
      case (d[2*i +: 2])
        2'b01: s = s + w;
        2'b11: s = s - w;
        2'b00: ;
        default: bad = 1'b1;
      endcase
      w = w * 3;
    end
    return s;
  endfunction

  // drive on a falling edge, strobe for one cycle; returns half a cycle after the sampling edge
  task automatic applyLevel(input int lvl);
    @(negedge clk);
    levelIn = LVL_W'(lvl);
    levelValid = 1'b1;
    @(negedge clk);
    levelValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    bit bad;
    int s;
    logic [7:0] held;

    // R1 during and after reset
    #13;
    chk(digitsOut == 8'h00 && !doneOut && !rangeErr, "R1 in reset", int'(digitsOut), 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(digitsOut == 8'h00 && !doneOut && !rangeErr, "R1 after reset", int'(digitsOut), 0);

    // R3 R4 R5: every legal level
    for (int lvl = -40; lvl <= 40; lvl++) begin
      applyLevel(lvl);
      chk(doneOut == 1'b1, "R5 done pulse", int'(doneOut), 1);
      s = sumDigits(digitsOut, bad);
      chk(!bad, "R4 no code 10", int'(digitsOut), int'(refDigits(lvl)));
      chk(s == lvl, "R3 weighted sum", s, lvl);
      chk(digitsOut == refDigits(lvl), "R2 encoding", int'(digitsOut), int'(refDigits(lvl)));
    end
    @(negedge clk);
    chk(doneOut == 1'b0, "R5 done one cycle", int'(doneOut), 0);
    chk(rangeErr == 1'b0, "R8 clear after in-range", int'(rangeErr), 0);

    // directed vector table: R9 carries, R7 saturation
    for (int i = 0; i < NVEC; i++) begin
      applyLevel(int'(vecLvl[i]));
      chk(digitsOut == vecDig[i], (i >= 10) ? "R7 saturation" : "R9 carry table",
          int'(digitsOut), int'(vecDig[i]));
      if (i == 9)
        chk(rangeErr == 1'b0, "R8 not yet set", int'(rangeErr), 0);
      if (i == 10)
        chk(rangeErr == 1'b1, "R8 set on out-of-range", int'(rangeErr), 1);
    end

    // R8 sticky through in-range request
    applyLevel(3);
    chk(digitsOut == 8'h04, "R2 level 3", int'(digitsOut), 4);
    chk(rangeErr == 1'b1, "R8 sticky", int'(rangeErr), 1);

    // R6 input changes without strobe are ignored
    held = digitsOut;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      levelIn = LVL_W'(k * 7 - 20);
      chk(digitsOut == held && !doneOut, "R6 hold", int'(digitsOut), int'(held));
    end

    // R1 reset clears sticky flag and digits
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(digitsOut == 8'h00 && !rangeErr && !doneOut, "R1 mid-run reset",
        int'({rangeErr, digitsOut}), 0);
    rstN = 1'b1;
    applyLevel(-27);
    chk(digitsOut == 8'hC0, "R3 level -27", int'(digitsOut), 8'hC0);
    chk(rangeErr == 1'b0, "R8 cleared by reset", int'(rangeErr), 0);

    finishRun();
  end
endmodule